// File: doc/BRIEF.md
# Six-Port Mesh Crosspoint Router with Message Classes

This block is one node of a two-dimensional on-chip mesh. It has six bidirectional ports: four link to the neighbouring nodes (north, east, south, west) and two connect to local devices. Each port carries four separate message classes: request, response, data and snoop. Every class on every input has its own small FIFO. Every class on every output has its own credit counter and its own round-robin arbiter. As a result, a stalled class never holds up another.

Each flit is a single-flit message. A header sits above the payload; by default the payload is 512 bits, so one 64-byte line moves per cycle per port. If the header's port mask is zero, the flit is routed by dimension order: X first, then Y. At its own coordinates the flit goes to one of the two device ports, chosen by a local-select bit. If the mask is nonzero, the flit is a multicast and is copied to every port in the mask. A copy leaves on each output as soon as that output has a credit. The flit leaves its input FIFO, and returns one credit upstream, only after its last copy has gone.

Top module: `mesh_xpt`

## Requirements
- R1: After reset no output lane is valid and no credit is returned upstream. Every output lane's credit count starts at CRD_MAX. Lane index = port*4 + class, with ports north=0, east=1, south=2, west=3, device0=4, device1=5, and classes request=0, response=1, data=2, snoop=3.
- R2: A flit with a zero port mask is routed one way only. It goes east when its X is greater than the router's and west when it is smaller. When X matches, it goes north when its Y is greater and south when its Y is smaller.
- R3: A unicast flit whose X and Y both match the router goes to device0 when its local-select bit is 0 and to device1 when the bit is 1.
- R4: A flit with a nonzero port mask (bit n = port n) is delivered on exactly the ports in the mask, and its coordinates are ignored.
- R5: An output lane whose credit count is zero offers nothing. It offers its next flit in the cycle after a credit returns.
- R6: A class that is blocked on a port does not delay a flit of another class on that same port.
- R7: Inputs that contend for one output lane are served in round-robin order. After reset the search starts at input 0, and after each grant it restarts just past the winner.
- R8: Each copy of a multicast flit leaves as soon as its output has a credit. Each target port receives exactly one copy. The flit stays at the head of its input until the last copy has gone.
- R9: The upstream credit return of an input lane pulses exactly once per flit, in the cycle the flit leaves that lane's FIFO.
- R10: Flits of one class from one input to one output leave in the order they arrived.
- R11: A flit accepted at a clock edge is offered on its outputs in the next cycle, with header and payload unchanged. The flit layout is {class(2), port mask(6), X(4), Y(4), local-select(1), payload}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_x | input | 4 | X coordinate of this node |
| my_y | input | 4 | Y coordinate of this node |
| in_valid | input | 24 | Flit present, one bit per input lane |
| in_flit | input | 24*(17+PAY_W) | Input flits, lane n at bits n*(17+PAY_W) upward |
| in_crd_ret | output | 24 | Credit returned to the upstream node, one per dequeued flit |
| out_valid | output | 24 | Flit offered, one bit per output lane |
| out_flit | output | 24*(17+PAY_W) | Output flits, laid out like in_flit |
| out_crd_ret | input | 24 | Credit returned by the downstream node |

## Verification
The bench builds the router with a 32-bit payload. This keeps the flit vectors short; the header, credit and arbitration logic stay as they are. FIFO depth and credit limit keep their default of 4. With a limit of 4, exhausting an output takes only a few flits, so a single short test can stall one class, show that another class on the same port keeps moving, and then release the stall. The same small limit makes it cheap to hold back one target of a multicast while its other copy goes ahead.

// File: rtl/mesh_pkg.sv
package mesh_pkg;
    localparam int NPORT = 6;
    localparam int NCLS  = 4;
    localparam int CW    = 4;

    typedef enum logic [2:0] {
        P_N  = 3'd0,
        P_E  = 3'd1,
        P_S  = 3'd2,
        P_W  = 3'd3,
        P_L0 = 3'd4,
        P_L1 = 3'd5
    } port_e;

    typedef enum logic [1:0] {
        C_REQ = 2'd0,
        C_RSP = 2'd1,
        C_DAT = 2'd2,
        C_SNP = 2'd3
    } cls_e;

    typedef struct packed {
        cls_e              cls;
        logic [NPORT-1:0]  mcast;
        logic [CW-1:0]     dx;
        logic [CW-1:0]     dy;
        logic              lsel;
    } hdr_t;

    localparam int HDR_W = $bits(hdr_t);

    function automatic logic [NPORT-1:0] port_bit(port_e p);
        logic [NPORT-1:0] m;
        m = '0;
        m[p] = 1'b1;
        return m;
    endfunction

    // dimension order: X settles first, then Y, then local device select
    function automatic logic [NPORT-1:0] route_xy(hdr_t h, logic [CW-1:0] mx, logic [CW-1:0] my);
        if (h.mcast != '0) return h.mcast;
        if (h.dx > mx)     return port_bit(P_E);
        if (h.dx < mx)     return port_bit(P_W);
        if (h.dy > my)     return port_bit(P_N);
        if (h.dy < my)     return port_bit(P_S);
        return h.lsel ? port_bit(P_L1) : port_bit(P_L0);
    endfunction
endpackage

// File: rtl/xpt_fifo.sv
module xpt_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] head,
    output logic         nonempty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNW = $clog2(DEPTH + 1);

    logic [W-1:0]   mem [DEPTH];
    logic [AW-1:0]  wp, rp;
    logic [CNW-1:0] cnt;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    assign head     = mem[rp];
    assign nonempty = (cnt != '0);

    // upstream may only push while holding a credit, so a full FIFO never sees a push
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt != CNW'(DEPTH)));
    p_no_underrun_r9: assert property (@(posedge clk) disable iff (rst)
        pop |-> (cnt != '0));
endmodule

// File: rtl/xpt_route.sv
module xpt_route
    import mesh_pkg::*;
(
    input  hdr_t              hdr,
    input  logic [CW-1:0]     my_x,
    input  logic [CW-1:0]     my_y,
    output logic [NPORT-1:0]  tgt
);
    assign tgt = route_xy(hdr, my_x, my_y);
endmodule

// File: rtl/xpt_rr_arb.sv
module xpt_rr_arb #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr;
    logic [IW-1:0] nxt;

    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        nxt   = ptr;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(ptr) + k) % N;
            if (!found && req[idx]) begin
                found    = 1'b1;
                gnt[idx] = 1'b1;
                nxt      = IW'((idx + 1) % N);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (|gnt) ptr <= nxt;
    end
endmodule

// File: rtl/xpt_credit.sv
module xpt_credit #(
    parameter int MAX = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic give,
    output logic ok
);
    localparam int CNW = $clog2(MAX + 1);

    logic [CNW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) cnt <= CNW'(MAX);
        else begin
            case ({take, give})
                2'b10:   cnt <= cnt - 1'b1;
                2'b01:   cnt <= cnt + 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign ok = (cnt != '0);

    p_credit_floor_r5: assert property (@(posedge clk) disable iff (rst)
        take |-> (cnt != '0));
    p_credit_ceiling_r5: assert property (@(posedge clk) disable iff (rst)
        (give && !take) |-> (cnt < CNW'(MAX)));
endmodule

// File: rtl/mesh_xpt.sv
module mesh_xpt
    import mesh_pkg::*;
#(
    parameter int PAY_W   = 512,
    parameter int FIFO_D  = 4,
    parameter int CRD_MAX = 4
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic [CW-1:0]                            my_x,
    input  logic [CW-1:0]                            my_y,
    input  logic [NPORT*NCLS-1:0]                    in_valid,
    input  logic [NPORT*NCLS*(HDR_W+PAY_W)-1:0]      in_flit,
    output logic [NPORT*NCLS-1:0]                    in_crd_ret,
    output logic [NPORT*NCLS-1:0]                    out_valid,
    output logic [NPORT*NCLS*(HDR_W+PAY_W)-1:0]      out_flit,
    input  logic [NPORT*NCLS-1:0]                    out_crd_ret
);
    localparam int FW = HDR_W + PAY_W;
    localparam int NL = NPORT * NCLS;

    logic [FW-1:0]    head   [NL];
    logic [NL-1:0]    hv;
    logic [NL-1:0]    deq;
    logic [NL-1:0]    crd_ok;
    logic [NPORT-1:0] tgt    [NL];
    logic [NPORT-1:0] sent   [NL];
    logic [NPORT-1:0] served [NL];
    logic [NPORT-1:0] req    [NL];
    logic [NPORT-1:0] gnt    [NL];

    // input side: one FIFO and one route unit per input lane
    for (genvar li = 0; li < NL; li++) begin : g_in
        xpt_fifo #(.W(FW), .DEPTH(FIFO_D)) u_fifo (
            .clk      (clk),
            .rst      (rst),
            .push     (in_valid[li]),
            .pop      (deq[li]),
            .din      (in_flit[li*FW +: FW]),
            .head     (head[li]),
            .nonempty (hv[li])
        );

        xpt_route u_route (
            .hdr  (hdr_t'(head[li][FW-1 -: HDR_W])),
            .my_x (my_x),
            .my_y (my_y),
            .tgt  (tgt[li])
        );

        always_ff @(posedge clk) begin
            if (rst || deq[li]) sent[li] <= '0;
            else                sent[li] <= sent[li] | served[li];
        end

        assign deq[li] = hv[li] && ((tgt[li] & ~sent[li] & ~served[li]) == '0);

        p_head_hold_r8: assert property (@(posedge clk) disable iff (rst)
            (hv[li] && !deq[li]) |=> (hv[li] && $stable(head[li])));
        p_one_copy_r8: assert property (@(posedge clk) disable iff (rst)
            (served[li] & sent[li]) == '0);
    end

    // requests per output lane, gated by that lane's credit
    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            for (int c = 0; c < NCLS; c++) begin
                for (int i = 0; i < NPORT; i++) begin
                    req[o*NCLS+c][i] = hv[i*NCLS+c] & tgt[i*NCLS+c][o]
                                     & ~sent[i*NCLS+c][o] & crd_ok[o*NCLS+c];
                    served[i*NCLS+c][o] = gnt[o*NCLS+c][i];
                end
            end
        end
    end

    // output side: one arbiter and one credit counter per output lane
    for (genvar lo = 0; lo < NL; lo++) begin : g_out
        xpt_rr_arb #(.N(NPORT)) u_arb (
            .clk (clk),
            .rst (rst),
            .req (req[lo]),
            .gnt (gnt[lo])
        );

        xpt_credit #(.MAX(CRD_MAX)) u_crd (
            .clk  (clk),
            .rst  (rst),
            .take (out_valid[lo]),
            .give (out_crd_ret[lo]),
            .ok   (crd_ok[lo])
        );

        assign out_valid[lo] = |gnt[lo];

        always_comb begin
            out_flit[lo*FW +: FW] = '0;
            for (int i = 0; i < NPORT; i++) begin
                if (gnt[lo][i]) out_flit[lo*FW +: FW] = head[i*NCLS + (lo % NCLS)];
            end
        end

        hdr_t ohdr;
        assign ohdr = hdr_t'(out_flit[lo*FW + PAY_W +: HDR_W]);

        p_class_lane_r6: assert property (@(posedge clk) disable iff (rst)
            out_valid[lo] |-> (ohdr.cls == cls_e'(lo % NCLS)));
    end

    assign in_crd_ret = deq;
endmodule

// File: tb/sim_mesh_xpt.sv
module sim_mesh_xpt;
    import mesh_pkg::*;

    localparam int PAY_W = 32;
    localparam int FW    = HDR_W + PAY_W;
    localparam int NL    = NPORT * NCLS;
    localparam int NV    = 12;

    // {src(3), cls(2), dx(4), dy(4), lsel(1), mask(6), expected ports(6)}; node sits at (2,2)
    localparam logic [25:0] VEC [NV] = '{
        {3'd3, 2'd0, 4'd3, 4'd2, 1'b0, 6'h00, 6'h02},
        {3'd1, 2'd1, 4'd1, 4'd2, 1'b0, 6'h00, 6'h08},
        {3'd2, 2'd2, 4'd2, 4'd3, 1'b0, 6'h00, 6'h01},
        {3'd0, 2'd3, 4'd2, 4'd0, 1'b0, 6'h00, 6'h04},
        {3'd3, 2'd0, 4'd3, 4'd0, 1'b0, 6'h00, 6'h02},
        {3'd1, 2'd1, 4'd2, 4'd2, 1'b0, 6'h00, 6'h10},
        {3'd0, 2'd2, 4'd2, 4'd2, 1'b1, 6'h00, 6'h20},
        {3'd4, 2'd3, 4'd2, 4'd2, 1'b0, 6'h0E, 6'h0E},
        {3'd5, 2'd0, 4'd0, 4'd0, 1'b0, 6'h31, 6'h31},
        {3'd2, 2'd1, 4'd0, 4'd3, 1'b0, 6'h00, 6'h08},
        {3'd4, 2'd2, 4'd1, 4'd1, 1'b0, 6'h00, 6'h08},
        {3'd3, 2'd3, 4'd2, 4'd1, 1'b0, 6'h00, 6'h04}
    };

    logic              clk = 1'b0;
    logic              rst;
    logic [CW-1:0]     my_x = 4'd2;
    logic [CW-1:0]     my_y = 4'd2;
    logic [NL-1:0]     in_valid;
    logic [NL*FW-1:0]  in_flit;
    logic [NL-1:0]     in_crd_ret;
    logic [NL-1:0]     out_valid;
    logic [NL*FW-1:0]  out_flit;
    logic [NL-1:0]     out_crd_ret;

    int n_chk = 0;
    int n_bad = 0;
    bit auto_ret = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mesh_xpt #(.PAY_W(PAY_W), .FIFO_D(4), .CRD_MAX(4)) u0 (
        .clk         (clk),
        .rst         (rst),
        .my_x        (my_x),
        .my_y        (my_y),
        .in_valid    (in_valid),
        .in_flit     (in_flit),
        .in_crd_ret  (in_crd_ret),
        .out_valid   (out_valid),
        .out_flit    (out_flit),
        .out_crd_ret (out_crd_ret)
    );

    task automatic nedge();
        @(negedge clk);
        out_crd_ret = auto_ret ? out_valid : '0;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic hdr_t mk(int dx, int dy, bit ls, logic [5:0] m);
        hdr_t h;
        h.cls   = C_REQ;
        h.mcast = m;
        h.dx    = CW'(dx);
        h.dy    = CW'(dy);
        h.lsel  = ls;
        return h;
    endfunction

    task automatic put(input int p, input int c, input hdr_t h, input logic [31:0] pay);
        h.cls = cls_e'(c);
        in_valid[p*NCLS+c] = 1'b1;
        in_flit[(p*NCLS+c)*FW +: FW] = {h, pay};
    endtask

    function automatic logic [31:0] opay(int o, int c);
        return out_flit[(o*NCLS+c)*FW +: PAY_W];
    endfunction

    task automatic reset_dut();
        rst = 1'b1;
        in_valid = '0;
        in_flit = '0;
        out_crd_ret = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        logic [31:0] got [8];
        int ng;
        reset_dut();
        chk(out_valid == '0, "R1 out_valid after reset", 64'(out_valid), 0);
        chk(in_crd_ret == '0, "R1 credit return after reset", 64'(in_crd_ret), 0);

        // table walk: R2 R3 R4 routing, R9 credit return, R11 payload
        auto_ret = 1'b1;
        for (int v = 0; v < NV; v++) begin
            logic [25:0] e;
            logic [NL-1:0] xv;
            int s, c;
            e = VEC[v];
            s = int'(e[25:23]);
            c = int'(e[22:21]);
            xv = '0;
            for (int o = 0; o < NPORT; o++) xv[o*NCLS+c] = e[o];
            nedge();
            in_valid = '0;
            put(s, c, mk(int'(e[20:17]), int'(e[16:13]), e[12], e[11:6]), 32'hA000 + v);
            nedge();
            in_valid = '0;
            chk(out_valid == xv, "R2/R3/R4 ports", 64'(out_valid), 64'(xv));
            chk(in_crd_ret == (NL'(1) << (s*NCLS+c)), "R9 credit pulse", 64'(in_crd_ret), 64'(NL'(1) << (s*NCLS+c)));
            for (int o = 0; o < NPORT; o++)
                if (e[o]) chk(opay(o, c) == 32'hA000 + v, "R11 payload", 64'(opay(o, c)), 64'(32'hA000 + v));
        end
        nedge();
        chk(out_valid == '0, "R11 one cycle per flit", 64'(out_valid), 0);

        // R5 credit stall, R10 order, R6 class independence
        reset_dut();
        auto_ret = 1'b0;
        ng = 0;
        for (int k = 0; k < 10; k++) begin
            nedge();
            in_valid = '0;
            if (k < 5) put(P_W, 0, mk(3, 2, 0, 6'h00), 32'hB0 + k);
            if (out_valid[P_E*NCLS+0]) begin
                if (ng < 8) got[ng] = opay(P_E, 0);
                ng++;
            end
        end
        chk(ng == 4, "R5 sends bounded by reset credits", 64'(ng), 4);
        for (int j = 0; j < 4; j++)
            chk(got[j] == 32'hB0 + j, "R10 order", 64'(got[j]), 64'(32'hB0 + j));
        nedge();
        put(P_W, 1, mk(3, 2, 0, 6'h00), 32'hC1);
        nedge();
        in_valid = '0;
        chk(out_valid[P_E*NCLS+1] == 1'b1, "R6 other class passes", 64'(out_valid[P_E*NCLS+1]), 1);
        chk(opay(P_E, 1) == 32'hC1, "R6 payload", 64'(opay(P_E, 1)), 64'hC1);
        chk(out_valid[P_E*NCLS+0] == 1'b0, "R5 held at zero credit", 64'(out_valid[P_E*NCLS+0]), 0);
        out_crd_ret[P_E*NCLS+0] = 1'b1;
        nedge();
        chk(out_valid[P_E*NCLS+0] == 1'b1, "R5 resumes after credit", 64'(out_valid[P_E*NCLS+0]), 1);
        chk(opay(P_E, 0) == 32'hB4, "R10 last in order", 64'(opay(P_E, 0)), 64'hB4);

        // R7 round robin between north and south toward east, data class
        reset_dut();
        auto_ret = 1'b1;
        ng = 0;
        for (int k = 0; k < 7; k++) begin
            nedge();
            in_valid = '0;
            if (k == 0) begin put(P_N, 2, mk(3, 2, 0, 6'h00), 32'h10); put(P_S, 2, mk(3, 2, 0, 6'h00), 32'h20); end
            if (k == 1) begin put(P_N, 2, mk(3, 2, 0, 6'h00), 32'h11); put(P_S, 2, mk(3, 2, 0, 6'h00), 32'h21); end
            if (out_valid[P_E*NCLS+2]) begin
                if (ng < 8) got[ng] = opay(P_E, 2);
                ng++;
            end
        end
        chk(ng == 4, "R7 all contenders served", 64'(ng), 4);
        chk(got[0] == 32'h10, "R7 first grant input 0", 64'(got[0]), 64'h10);
        chk(got[1] == 32'h20, "R7 alternates", 64'(got[1]), 64'h20);
        chk(got[2] == 32'h11, "R7 wraps", 64'(got[2]), 64'h11);
        chk(got[3] == 32'h21, "R7 alternates again", 64'(got[3]), 64'h21);

        // R8 multicast with one target out of credit
        reset_dut();
        auto_ret = 1'b0;
        for (int k = 0; k < 6; k++) begin
            nedge();
            in_valid = '0;
            if (k < 4) put(P_S, 3, mk(2, 3, 0, 6'h00), 32'hE0 + k);
        end
        nedge();
        put(P_W, 3, mk(0, 0, 0, 6'h03), 32'hD0);
        nedge();
        in_valid = '0;
        chk(out_valid[P_E*NCLS+3] == 1'b1, "R8 ready copy goes early", 64'(out_valid[P_E*NCLS+3]), 1);
        chk(opay(P_E, 3) == 32'hD0, "R8 early copy payload", 64'(opay(P_E, 3)), 64'hD0);
        chk(out_valid[P_N*NCLS+3] == 1'b0, "R8 blocked copy waits", 64'(out_valid[P_N*NCLS+3]), 0);
        chk(in_crd_ret[P_W*NCLS+3] == 1'b0, "R8 head kept", 64'(in_crd_ret[P_W*NCLS+3]), 0);
        nedge();
        chk(out_valid[P_E*NCLS+3] == 1'b0, "R8 no second copy", 64'(out_valid[P_E*NCLS+3]), 0);
        chk(in_crd_ret[P_W*NCLS+3] == 1'b0, "R9 no early credit", 64'(in_crd_ret[P_W*NCLS+3]), 0);
        out_crd_ret[P_N*NCLS+3] = 1'b1;
        nedge();
        chk(out_valid[P_N*NCLS+3] == 1'b1, "R8 late copy", 64'(out_valid[P_N*NCLS+3]), 1);
        chk(opay(P_N, 3) == 32'hD0, "R8 late copy payload", 64'(opay(P_N, 3)), 64'hD0);
        chk(in_crd_ret[P_W*NCLS+3] == 1'b1, "R9 credit on last copy", 64'(in_crd_ret[P_W*NCLS+3]), 1);
        nedge();
        chk(out_valid == '0, "R8 flit retired", 64'(out_valid), 0);
        chk(in_crd_ret == '0, "R9 single pulse", 64'(in_crd_ret), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule